// File: doc/BRIEF.md
# Configuration-Mode Unlock and Register File

This block guards the configuration space of a multi-function peripheral chip that sits behind legacy host I/O ports. It watches every host write on a simple synchronous address/data/strobe bus. It opens configuration mode only when a fixed two-byte key (87h twice, back to back) arrives at the configuration base port. A strap bit sampled at reset picks that base port: 3F0h or 370h. The bit can later be rewritten from inside configuration mode.

In configuration mode the base port works as an index register and base+1 as a data register. Through this pair the host reaches a small bank of registers:
- a strap/status register with a read-only keyboard-controller enable and a defaults-control bit;
- a tri-state control register;
- a floppy/mode register that also holds a lock bit;
- a group of address-select registers.

Writing AAh to the index port leaves configuration mode. The lock bit freezes all data-port access until the next reset. A 0-to-1 change of the defaults-control bit reloads the address-select registers with their defaults.

The unlock controller has three named states. **IDLE** is no key seen. **KEY1** is one key byte seen. **CONFIG** is configuration mode. Its transitions are:
- *first_key*: IDLE→KEY1.
- *second_key*: KEY1→CONFIG.
- *key_broken*: KEY1→IDLE, on any other write.
- *exit_cmd*: CONFIG→IDLE.
- All other writes hold the state.

Top module: `cfg_port_ctrl`

## Requirements
- R1: `cfg_active` rises on the clock edge that captures the second of two consecutive bus writes of 87h to the current base port.
- R2: The base port is 3F0h when mode register bit 6 is 0 and 370h when it is 1. That bit takes the value of `strap_alt_base` at reset, and a write to it moves the index/data pair at once.
- R3: A write of any other value or to any other address between the two key bytes sends the controller back to IDLE, so two fresh key bytes are needed.
- R4: Writing AAh to the index port in configuration mode clears `cfg_active` on that edge.
- R5: Outside configuration mode, reads of the index and data ports give `rd_valid` low and writes other than key bytes leave all registers unchanged.
- R6: While mode register bit 5 (lock) is 1, data-port reads give `rd_valid` low and data-port writes change nothing. Index-port reads and the AAh exit still work.
- R7: Bit 2 of register 22h (keyboard enable, also on `kbc_enable`) equals `strap_kbc_en` at reset and ignores writes.
- R8: Bit 0 of register 22h resets to `strap_pnp_nodef`. At reset the address-select registers 30h..33h hold 10h, 20h, 30h, 40h when that strap is 0, and 00h when it is 1.
- R9: A write to register 22h bit 0 acts only when it complements the current value. A 0-to-1 change reloads 10h/20h/30h/40h into registers 30h..33h, and rewriting the current value leaves them unchanged.
- R10: Tri-state register 25h resets to 00h. Only bits 5, 4, 3 and 0 are writable, and the other bits read 0.
- R11: Mode register 26h keeps bit 7 (four-drive select), bit 6 (base select), bit 5 (lock) and bit 3 (floppy legacy IRQ/DRQ off). Other bits read 0. Bits 7 and 3 drive `four_drive` and `fdc_legacy_off`.
- R12: A read returns its data with `rd_valid` high in the cycle after the `bus_rd` cycle. The index port reads back the current index, and unmapped indices read 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; straps are captured while it is high |
| strap_kbc_en | input | 1 | Strap for keyboard-controller enable |
| strap_pnp_nodef | input | 1 | Strap for the address-select defaults-control bit |
| strap_alt_base | input | 1 | Strap for base port select (1 = 370h) |
| bus_addr | input | 16 | Host I/O address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data, registered |
| rd_valid | output | 1 | Read data valid, one cycle after `bus_rd` |
| cfg_active | output | 1 | Configuration mode is open |
| kbc_enable | output | 1 | Keyboard-controller enable bit |
| tri_ctl | output | 8 | Tri-state control register |
| four_drive | output | 1 | Four-drive floppy select |
| fdc_legacy_off | output | 1 | Floppy legacy IRQ/DRQ selection disabled |
| cfg_locked | output | 1 | Lock bit |
| asel_values | output | 32 | Address-select registers, register 30h in the low byte |

## Verification
Some conditions can only be reached through a chain of earlier writes. The reload of the address-select registers needs the defaults-control bit to go 0 then 1 after a register has been overwritten. The alternate base port needs either a second reset with a different strap or a mode write that moves the port under the host's feet. The stimulus reaches these by first overwriting an address-select register and then toggling bit 0 both redundantly and complementarily. It also rewrites the base-select bit from inside configuration mode and exits at the new port. Finally it applies a second reset with every strap inverted. The lock is tested last, because only a reset clears it.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_KEY1   = 2'd1,
        ST_CONFIG = 2'd2
    } unlock_st_t;

    localparam int CFG_DW = 8;
    localparam int CFG_AW = 16;

    localparam logic [CFG_DW-1:0] KEY_BYTE  = 8'h87;
    localparam logic [CFG_DW-1:0] EXIT_BYTE = 8'hAA;

    localparam logic [CFG_AW-1:0] BASE_PRI = 16'h03F0;
    localparam logic [CFG_AW-1:0] BASE_ALT = 16'h0370;

    localparam logic [CFG_DW-1:0] IDX_STRAP = 8'h22;
    localparam logic [CFG_DW-1:0] IDX_TRI   = 8'h25;
    localparam logic [CFG_DW-1:0] IDX_MODE  = 8'h26;
    localparam logic [CFG_DW-1:0] IDX_ASEL0 = 8'h30;

    localparam logic [CFG_DW-1:0] TRI_WMASK  = 8'h39;
    localparam logic [CFG_DW-1:0] MODE_WMASK = 8'hE8;

    localparam int MODE_ALT_BIT  = 6;
    localparam int MODE_LOCK_BIT = 5;
    localparam int MODE_4FD_BIT  = 7;
    localparam int MODE_LEG_BIT  = 3;

    function automatic logic [CFG_DW-1:0] asel_default(input int i);
        return CFG_DW'((i + 1) * 16);
    endfunction

endpackage

// File: rtl/cfg_unlock_fsm.sv
module cfg_unlock_fsm
    import cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [CFG_AW-1:0] bus_addr,
    input  logic [CFG_DW-1:0] bus_wdata,
    input  logic [CFG_AW-1:0] base_port,
    output logic              cfg_mode
);

    unlock_st_t state_q, state_d;

    logic at_base;
    logic key_hit;
    logic exit_hit;

    assign at_base  = (bus_addr == base_port);
    assign key_hit  = bus_wr && at_base && (bus_wdata == KEY_BYTE);
    assign exit_hit = bus_wr && at_base && (bus_wdata == EXIT_BYTE);

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (key_hit) state_d = ST_KEY1;             // first_key
            end
            ST_KEY1: begin
                if (key_hit)     state_d = ST_CONFIG;       // second_key
                else if (bus_wr) state_d = ST_IDLE;         // key_broken
            end
            ST_CONFIG: begin
                if (exit_hit) state_d = ST_IDLE;            // exit_cmd
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_CONFIG: cfg_mode = 1'b1;
            default:   cfg_mode = 1'b0;
        endcase
    end

endmodule

// File: rtl/cfg_asel_bank.sv
module cfg_asel_bank
    import cfg_pkg::*;
#(
    parameter int NUM = 4
)(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  strap_nodef,
    input  logic                  reload,
    input  logic [NUM-1:0]        we,
    input  logic [CFG_DW-1:0]     wdata,
    output logic [NUM*CFG_DW-1:0] values
);

    for (genvar i = 0; i < NUM; i++) begin : g_reg
        localparam logic [CFG_DW-1:0] DEF = asel_default(i);
        logic [CFG_DW-1:0] q;

        always_ff @(posedge clk) begin
            if (rst)        q <= strap_nodef ? '0 : DEF;
            else if (reload) q <= DEF;
            else if (we[i]) q <= wdata;
        end

        assign values[i*CFG_DW +: CFG_DW] = q;
    end

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
    import cfg_pkg::*;
#(
    parameter int NUM = 4
)(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  strap_kbc_en,
    input  logic                  strap_pnp_nodef,
    input  logic                  strap_alt_base,
    input  logic                  cfg_mode,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [CFG_AW-1:0]     bus_addr,
    input  logic [CFG_DW-1:0]     bus_wdata,
    input  logic [NUM*CFG_DW-1:0] asel_values,
    output logic [CFG_AW-1:0]     base_port,
    output logic [CFG_DW-1:0]     rd_data,
    output logic                  rd_valid,
    output logic                  kbc_en,
    output logic                  pnp_nodef,
    output logic [CFG_DW-1:0]     tri_q,
    output logic [CFG_DW-1:0]     mode_q,
    output logic [NUM-1:0]        asel_we,
    output logic                  asel_reload
);

    logic [CFG_DW-1:0] index_q;
    logic              locked;
    logic              at_index, at_data;
    logic              idx_wr, dat_wr;
    logic [CFG_DW-1:0] strap_view;
    logic [CFG_DW-1:0] reg_view;
    logic              rvalid_d;
    logic [CFG_DW-1:0] rdata_d;

    assign base_port = mode_q[MODE_ALT_BIT] ? BASE_ALT : BASE_PRI;
    assign locked    = mode_q[MODE_LOCK_BIT];
    assign at_index  = (bus_addr == base_port);
    assign at_data   = (bus_addr == base_port + 16'd1);
    assign idx_wr    = cfg_mode && bus_wr && at_index;
    assign dat_wr    = cfg_mode && bus_wr && at_data && !locked;

    assign strap_view = {5'b0, kbc_en, 1'b0, pnp_nodef};

    always_ff @(posedge clk) begin
        if (rst)         index_q <= '0;
        else if (idx_wr) index_q <= bus_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            kbc_en    <= strap_kbc_en;
            pnp_nodef <= strap_pnp_nodef;
        end else if (dat_wr && index_q == IDX_STRAP && bus_wdata[0] != pnp_nodef) begin
            pnp_nodef <= bus_wdata[0];
        end
    end

    assign asel_reload = dat_wr && (index_q == IDX_STRAP) && !pnp_nodef && bus_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            tri_q  <= '0;
            mode_q <= '0;
            mode_q[MODE_ALT_BIT] <= strap_alt_base;
        end else if (dat_wr) begin
            if (index_q == IDX_TRI)  tri_q  <= bus_wdata & TRI_WMASK;
            if (index_q == IDX_MODE) mode_q <= bus_wdata & MODE_WMASK;
        end
    end

    always_comb begin
        for (int i = 0; i < NUM; i++) begin
            asel_we[i] = dat_wr && (index_q == IDX_ASEL0 + CFG_DW'(i));
        end
    end

    always_comb begin
        reg_view = '0;
        if (index_q == IDX_STRAP)     reg_view = strap_view;
        else if (index_q == IDX_TRI)  reg_view = tri_q;
        else if (index_q == IDX_MODE) reg_view = mode_q;
        else begin
            for (int i = 0; i < NUM; i++) begin
                if (index_q == IDX_ASEL0 + CFG_DW'(i))
                    reg_view = asel_values[i*CFG_DW +: CFG_DW];
            end
        end
    end

    always_comb begin
        rvalid_d = 1'b0;
        rdata_d  = '0;
        if (bus_rd && cfg_mode) begin
            if (at_index) begin
                rvalid_d = 1'b1;
                rdata_d  = index_q;
            end else if (at_data && !locked) begin
                rvalid_d = 1'b1;
                rdata_d  = reg_view;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rvalid_d;
            rd_data  <= rdata_d;
        end
    end

endmodule

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl
    import cfg_pkg::*;
#(
    parameter int ASEL_NUM = 4
)(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       strap_kbc_en,
    input  logic                       strap_pnp_nodef,
    input  logic                       strap_alt_base,
    input  logic [CFG_AW-1:0]          bus_addr,
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    input  logic [CFG_DW-1:0]          bus_wdata,
    output logic [CFG_DW-1:0]          rd_data,
    output logic                       rd_valid,
    output logic                       cfg_active,
    output logic                       kbc_enable,
    output logic [CFG_DW-1:0]          tri_ctl,
    output logic                       four_drive,
    output logic                       fdc_legacy_off,
    output logic                       cfg_locked,
    output logic [ASEL_NUM*CFG_DW-1:0] asel_values
);

    logic [CFG_AW-1:0]   base_port;
    logic                cfg_mode;
    logic                pnp_nodef;
    logic [CFG_DW-1:0]   mode_q;
    logic [ASEL_NUM-1:0] asel_we;
    logic                asel_reload;

    cfg_unlock_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .base_port (base_port),
        .cfg_mode  (cfg_mode)
    );

    cfg_regfile #(.NUM(ASEL_NUM)) u_regs (
        .clk             (clk),
        .rst             (rst),
        .strap_kbc_en    (strap_kbc_en),
        .strap_pnp_nodef (strap_pnp_nodef),
        .strap_alt_base  (strap_alt_base),
        .cfg_mode        (cfg_mode),
        .bus_wr          (bus_wr),
        .bus_rd          (bus_rd),
        .bus_addr        (bus_addr),
        .bus_wdata       (bus_wdata),
        .asel_values     (asel_values),
        .base_port       (base_port),
        .rd_data         (rd_data),
        .rd_valid        (rd_valid),
        .kbc_en          (kbc_enable),
        .pnp_nodef       (pnp_nodef),
        .tri_q           (tri_ctl),
        .mode_q          (mode_q),
        .asel_we         (asel_we),
        .asel_reload     (asel_reload)
    );

    cfg_asel_bank #(.NUM(ASEL_NUM)) u_asel (
        .clk         (clk),
        .rst         (rst),
        .strap_nodef (strap_pnp_nodef),
        .reload      (asel_reload),
        .we          (asel_we),
        .wdata       (bus_wdata),
        .values      (asel_values)
    );

    assign cfg_active     = cfg_mode;
    assign four_drive     = mode_q[MODE_4FD_BIT];
    assign fdc_legacy_off = mode_q[MODE_LEG_BIT];
    assign cfg_locked     = mode_q[MODE_LOCK_BIT];

endmodule

// File: rtl/cfg_port_ctrl_chk.sv
module cfg_port_ctrl_chk
    import cfg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [CFG_AW-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [CFG_DW-1:0] bus_wdata,
    input logic              rd_valid,
    input logic              cfg_active,
    input logic              kbc_enable,
    input logic              cfg_locked,
    input logic [CFG_DW-1:0] tri_ctl,
    input logic [CFG_AW-1:0] base_port
);

    // R1
    unlock_key_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_active) |-> $past(bus_wr && bus_wdata == KEY_BYTE && bus_addr == base_port));

    // R4
    exit_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_active && bus_wr && bus_addr == base_port && bus_wdata == EXIT_BYTE) |=> !cfg_active);

    // R5
    closed_read_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_active && bus_rd) |=> !rd_valid);

    // R6
    lock_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_locked && bus_wr) |=> ($stable(tri_ctl) && cfg_locked));

    // R7
    kbc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> $stable(kbc_enable));

    // R12
    read_latency_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(bus_rd));

endmodule

bind cfg_port_ctrl cfg_port_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .rd_valid   (rd_valid),
    .cfg_active (cfg_active),
    .kbc_enable (kbc_enable),
    .cfg_locked (cfg_locked),
    .tri_ctl    (tri_ctl),
    .base_port  (base_port)
);

// File: tb/cfg_port_ctrl_tb.sv
module cfg_port_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strap_kbc_en = 1'b1;
    logic        strap_pnp_nodef = 1'b0;
    logic        strap_alt_base = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic        cfg_active;
    logic        kbc_enable;
    logic [7:0]  tri_ctl;
    logic        four_drive;
    logic        fdc_legacy_off;
    logic        cfg_locked;
    logic [31:0] asel_values;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] base = 16'h03F0;

    always #4 clk = ~clk;

    cfg_port_ctrl u_dut (
        .clk(clk), .rst(rst),
        .strap_kbc_en(strap_kbc_en), .strap_pnp_nodef(strap_pnp_nodef),
        .strap_alt_base(strap_alt_base),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .rd_data(rd_data), .rd_valid(rd_valid), .cfg_active(cfg_active),
        .kbc_enable(kbc_enable), .tri_ctl(tri_ctl), .four_drive(four_drive),
        .fdc_legacy_off(fdc_legacy_off), .cfg_locked(cfg_locked),
        .asel_values(asel_values)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d, output logic v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = rd_data; v = rd_valid;
    endtask

    task automatic unlock();
        wr(base, 8'h87);
        wr(base, 8'h87);
    endtask

    task automatic wreg(input logic [7:0] idx, input logic [7:0] d);
        wr(base, idx);
        wr(base + 16'd1, d);
    endtask

    task automatic rreg(input logic [7:0] idx, output logic [7:0] d, output logic v);
        wr(base, idx);
        rd(base + 16'd1, d, v);
    endtask

    task automatic do_reset(input logic kbc, input logic nodef, input logic alt);
        @(negedge clk);
        rst = 1'b1;
        strap_kbc_en = kbc; strap_pnp_nodef = nodef; strap_alt_base = alt;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        base = alt ? 16'h0370 : 16'h03F0;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        check("R10 tri reset", {24'h0, tri_ctl}, 32'h0);
        check("R4 idle after reset", {31'h0, cfg_active}, 32'h0);
        check("R7 kbc strap", {31'h0, kbc_enable}, 32'h1);
        check("R8 asel defaults", asel_values, 32'h40302010);
    endtask

    task automatic t_unlock();
        logic [7:0] d; logic v;
        rd(base, d, v);
        check("R5 closed read valid", {31'h0, v}, 32'h0);
        wr(base, 8'h87);
        check("R1 one key not enough", {31'h0, cfg_active}, 32'h0);
        wr(base, 8'h87);
        check("R1 two keys open", {31'h0, cfg_active}, 32'h1);
        wr(base, 8'h25);
        rd(base, d, v);
        check("R12 index readback", {23'h0, v, d}, {23'h0, 1'b1, 8'h25});
        rreg(8'h77, d, v);
        check("R12 unmapped index", {23'h0, v, d}, {23'h0, 1'b1, 8'h00});
    endtask

    task automatic t_fields();
        logic [7:0] d; logic v;
        wreg(8'h25, 8'hFF);
        check("R10 tri output", {24'h0, tri_ctl}, 32'h39);
        rreg(8'h25, d, v);
        check("R10 tri readback", {24'h0, d}, 32'h39);
        wreg(8'h26, 8'h9F);
        rreg(8'h26, d, v);
        check("R11 mode readback", {24'h0, d}, 32'h88);
        check("R11 mode outputs", {30'h0, four_drive, fdc_legacy_off}, 32'h3);
        wreg(8'h22, 8'hFE);
        rreg(8'h22, d, v);
        check("R7 kbc read only", {24'h0, d}, 32'h04);
        check("R7 kbc output", {31'h0, kbc_enable}, 32'h1);
    endtask

    task automatic t_toggle();
        logic [7:0] d; logic v;
        wreg(8'h30, 8'h55);
        rreg(8'h30, d, v);
        check("R9 asel written", {24'h0, d}, 32'h55);
        wreg(8'h22, 8'h01);
        check("R9 0->1 reload", asel_values, 32'h40302010);
        wreg(8'h30, 8'h77);
        wreg(8'h22, 8'h01);
        check("R9 same value no reload", asel_values[7:0], 32'h77);
        wreg(8'h22, 8'h00);
        check("R9 1->0 no reload", asel_values[7:0], 32'h77);
        wreg(8'h22, 8'h01);
        rreg(8'h30, d, v);
        check("R9 second reload", {24'h0, d}, 32'h10);
    endtask

    task automatic t_exit_closed();
        logic [7:0] d; logic v;
        wr(base, 8'hAA);
        check("R4 exit", {31'h0, cfg_active}, 32'h0);
        wr(base, 8'h25);
        wr(base + 16'd1, 8'h00);
        check("R5 closed write ignored", {24'h0, tri_ctl}, 32'h39);
        rd(base + 16'd1, d, v);
        check("R5 closed data read", {31'h0, v}, 32'h0);
    endtask

    task automatic t_broken_key();
        wr(base, 8'h87);
        wr(16'h0080, 8'h00);
        wr(base, 8'h87);
        check("R3 other address breaks key", {31'h0, cfg_active}, 32'h0);
        wr(base, 8'h86);
        wr(base, 8'h87);
        check("R3 other value breaks key", {31'h0, cfg_active}, 32'h0);
        wr(base, 8'h87);
        check("R3 fresh pair opens", {31'h0, cfg_active}, 32'h1);
    endtask

    task automatic t_base_move();
        wreg(8'h26, 8'h40);
        base = 16'h0370;
        wr(base, 8'hAA);
        check("R2 exit at moved base", {31'h0, cfg_active}, 32'h0);
        wr(16'h03F0, 8'h87);
        wr(16'h03F0, 8'h87);
        check("R2 old base refused", {31'h0, cfg_active}, 32'h0);
        unlock();
        check("R2 new base opens", {31'h0, cfg_active}, 32'h1);
    endtask

    task automatic t_strap_reset();
        logic [7:0] d; logic v;
        do_reset(1'b0, 1'b1, 1'b1);
        check("R7 kbc strap low", {31'h0, kbc_enable}, 32'h0);
        check("R8 no defaults", asel_values, 32'h0);
        wr(16'h03F0, 8'h87);
        wr(16'h03F0, 8'h87);
        check("R2 strap alt refuses 3F0", {31'h0, cfg_active}, 32'h0);
        unlock();
        check("R2 strap alt opens 370", {31'h0, cfg_active}, 32'h1);
        rreg(8'h22, d, v);
        check("R8 strap reg", {24'h0, d}, 32'h01);
        rreg(8'h26, d, v);
        check("R2 mode alt bit", {24'h0, d}, 32'h40);
    endtask

    task automatic t_lock();
        logic [7:0] d; logic v;
        wreg(8'h25, 8'h08);
        wreg(8'h26, 8'h60);
        check("R6 locked", {31'h0, cfg_locked}, 32'h1);
        wreg(8'h25, 8'h31);
        check("R6 write frozen", {24'h0, tri_ctl}, 32'h08);
        rreg(8'h25, d, v);
        check("R6 data read blocked", {31'h0, v}, 32'h0);
        rd(base, d, v);
        check("R6 index still reads", {23'h0, v, d}, {23'h0, 1'b1, 8'h25});
        wr(base, 8'hAA);
        check("R6 exit while locked", {31'h0, cfg_active}, 32'h0);
    endtask

    initial begin
        #1600000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_unlock();
        t_fields();
        t_toggle();
        t_exit_closed();
        t_broken_key();
        t_base_move();
        t_strap_reset();
        t_lock();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule